// File: doc/BRIEF.md
# Delayed Conditional Branch Fetch Controller

This block drives instruction fetch for a three-stage in-order pipeline (fetch, decode, execute). The pipeline supports conditional branches with one delay slot. An external decoder looks at the instruction word in the decode stage and returns three things: whether it is a conditional branch, the branch polarity and an 8-bit displacement. The block holds the program counter and the decode and execute stage registers. It decides in decode whether the branch is taken. It forms the target while the branch is in execute, and it steers the fetch address.

A taken branch does not cancel the instruction that follows it. That instruction, the delay slot, still runs. The fetch issued while the branch is in execute is marked with `kill`. It enters decode as invalid and never executes. The cycle after that issues no fetch, and fetch of the target starts in the cycle after the delay-slot instruction has left execute. A branch whose condition fails causes no lost slot. A conditional branch placed in a delay slot is illegal: it is not evaluated, and it raises `slot_err` while it is in execute.

Top module: `dbr_fetch_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after its release, `fetch_addr` equals RESET_VEC (default 0x100) and `fetch_valid` is 1. In that same window `id_valid`, `ex_valid`, `kill` and `slot_err` are all 0.
- R2: With no taken branch, each valid fetch is followed in the next cycle by a fetch at the previous address plus 2. Every fetched word moves to decode and then to execute in the two following cycles, keeping its address.
- R3: A valid conditional branch in decode is taken exactly when `cond_flag` equals `dec_pol`. `dec_pol`=1 branches on a set flag and `dec_pol`=0 branches on a clear flag.
- R4: The instruction fetched right after a taken branch (the delay slot) reaches execute valid in the cycle after the branch.
- R5: In the cycle a taken branch is in execute, `kill` is 1 and the fetch issued in that cycle is at the branch address plus 4. That instruction enters decode invalid and never reaches execute.
- R6: The target is the branch address plus 4 plus the sign-extended displacement times 2. It is fetched valid two cycles after the `kill` cycle, and `fetch_valid` is 0 in the cycle between.
- R7: When a branch is not taken, `kill` stays 0 and fetching continues sequentially with no invalid slot.
- R8: A conditional branch in decode while a conditional branch is in execute is never taken. It causes no redirect, and `slot_err` is 1 while it is in execute. `slot_err` is 0 for every other executing instruction.
- R9: A branch indication for an invalid decode stage (a discarded fetch) has no effect: it causes no `kill` and no redirect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_flag | input | 1 | Condition flag tested by conditional branches |
| fetch_word | input | 16 | Instruction word returned for `fetch_addr` in the same cycle |
| dec_is_bcond | input | 1 | Decode-stage word is a conditional branch |
| dec_pol | input | 1 | Branch polarity: 1 branches on set flag, 0 on clear flag |
| dec_disp | input | 8 | Signed branch displacement in halfwords |
| fetch_addr | output | 32 | Fetch address |
| fetch_valid | output | 1 | A fetch is issued this cycle |
| kill | output | 1 | This cycle's fetch is on the wrong path and is discarded |
| id_valid | output | 1 | Decode stage holds a live instruction |
| id_instr | output | 16 | Decode-stage instruction word |
| id_pc | output | 32 | Decode-stage instruction address |
| ex_valid | output | 1 | Execute stage holds a live instruction |
| ex_instr | output | 16 | Execute-stage instruction word |
| ex_pc | output | 32 | Execute-stage instruction address |
| slot_err | output | 1 | Executing instruction is an illegal branch in a delay slot |

## Verification
The assertions assume that the decode inputs describe the word in `id_instr` in the same cycle, and that `cond_flag` is meaningful whenever a branch sits in decode. They also take it that an instruction word is returned combinationally for every fetch address. The bench meets these assumptions by deriving `dec_is_bcond`, `dec_pol` and `dec_disp` straight from `id_instr` and by serving `fetch_word` from a fixed program. It changes `cond_flag` only while reset is held. The program runs once with the flag set and once with it clear. This covers forward and backward targets, both polarities, a branch in the discarded slot and a branch in a delay slot.

// File: rtl/dbr_fetch_pkg.sv
// Package for the delayed-branch fetch controller.
// Holds the fetch sequencer state type shared by the modules.
package dbr_fetch_pkg;

    // Fetch sequencer: normal streaming, or the one dead slot after a redirect.
    typedef enum logic {
        FQ_RUN    = 1'b0,
        FQ_BUBBLE = 1'b1
    } fq_state_e;

endpackage

// File: rtl/dbr_fetch_pc.sv
// Program counter and fetch sequencer.
// Issues one fetch per cycle at pc, stepping by STEP bytes. A redirect loads
// the target and skips exactly one fetch slot.
// Assumes: redirect is never raised in the skipped slot.
module dbr_fetch_pc
    import dbr_fetch_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 32,
    parameter int unsigned          STEP      = 2,
    parameter logic [ADDR_W-1:0]    RESET_VEC = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_valid
);

    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

    fq_state_e         st_q;
    logic [ADDR_W-1:0] pc_q;

    // Advance, redirect or hold the program counter each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_VEC;
            st_q <= FQ_RUN;
        end else if (redirect) begin
            pc_q <= redirect_addr;
            st_q <= FQ_BUBBLE;
        end else if (st_q == FQ_BUBBLE) begin
            st_q <= FQ_RUN;
        end else begin
            pc_q <= pc_q + STEP_A;
        end
    end

    assign fetch_addr  = pc_q;
    assign fetch_valid = (st_q == FQ_RUN);

    assert_redirect_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (!fetch_valid && fetch_addr == $past(redirect_addr)));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !redirect) |=> (fetch_addr == $past(fetch_addr) + STEP_A));

endmodule

// File: rtl/dbr_branch_unit.sv
// Branch decision and target formation.
// Decides taken / not taken for the decode-stage branch. Flags a branch that
// sits in a delay slot as illegal. Forms the target from the executing branch.
// Assumes: decoder inputs describe the current decode-stage word.
module dbr_branch_unit #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DISP_W = 8,
    parameter int unsigned STEP   = 2
) (
    input  logic              id_valid,
    input  logic              dec_is_bcond,
    input  logic              dec_pol,
    input  logic              cond_flag,
    input  logic              ex_br,
    input  logic [ADDR_W-1:0] ex_pc,
    input  logic [DISP_W-1:0] ex_disp,
    output logic              br_legal,
    output logic              br_taken,
    output logic              br_illegal,
    output logic [ADDR_W-1:0] target
);

    localparam int unsigned       SHIFT  = $clog2(STEP);
    localparam logic [ADDR_W-1:0] OFFSET = ADDR_W'(2 * STEP);

    logic              id_br;
    logic [ADDR_W-1:0] disp_ext;

    // Resolve the decode-stage branch against the flag and the slot rule.
    always_comb begin
        id_br      = id_valid && dec_is_bcond;
        br_illegal = id_br && ex_br;
        br_legal   = id_br && !ex_br;
        br_taken   = br_legal && (cond_flag == dec_pol);
    end

    // Form the branch target from the executing branch's own address.
    always_comb begin
        disp_ext = {{(ADDR_W-DISP_W){ex_disp[DISP_W-1]}}, ex_disp};
        target   = ex_pc + OFFSET + (disp_ext << SHIFT);
    end

endmodule

// File: rtl/dbr_stage_regs.sv
// Decode and execute pipeline registers.
// A killed fetch enters decode with its valid bit clear. Branch outcome bits
// travel with the branch into execute.
// Assumes: branch outcome inputs are already qualified by id_valid.
module dbr_stage_regs #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned INSTR_W = 16,
    parameter int unsigned DISP_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    input  logic               kill,
    input  logic [ADDR_W-1:0]  fetch_addr,
    input  logic [INSTR_W-1:0] fetch_word,
    input  logic [DISP_W-1:0]  dec_disp,
    input  logic               br_legal,
    input  logic               br_taken,
    input  logic               br_illegal,
    output logic               id_valid,
    output logic [INSTR_W-1:0] id_instr,
    output logic [ADDR_W-1:0]  id_pc,
    output logic               ex_valid,
    output logic [INSTR_W-1:0] ex_instr,
    output logic [ADDR_W-1:0]  ex_pc,
    output logic [DISP_W-1:0]  ex_disp,
    output logic               ex_br,
    output logic               ex_taken,
    output logic               ex_err
);

    // Capture the fetched word into decode; a killed fetch lands invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_valid <= 1'b0;
            id_instr <= '0;
            id_pc    <= '0;
        end else begin
            id_valid <= fetch_valid && !kill;
            id_instr <= fetch_word;
            id_pc    <= fetch_addr;
        end
    end

    // Move decode into execute together with its branch outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_valid <= 1'b0;
            ex_instr <= '0;
            ex_pc    <= '0;
            ex_disp  <= '0;
            ex_br    <= 1'b0;
            ex_taken <= 1'b0;
            ex_err   <= 1'b0;
        end else begin
            ex_valid <= id_valid;
            ex_instr <= id_instr;
            ex_pc    <= id_pc;
            ex_disp  <= dec_disp;
            ex_br    <= br_legal;
            ex_taken <= br_taken;
            ex_err   <= br_illegal;
        end
    end

    assert_kill_squash_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !id_valid);

    assert_stage_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |=> (ex_valid && ex_pc == $past(id_pc)));

endmodule

// File: rtl/dbr_fetch_ctrl.sv
// Top of the delayed conditional branch fetch controller.
// Connects the fetch sequencer, stage registers and branch unit. A taken
// branch in execute kills the current fetch and redirects to its target.
// Assumes: fetch_word arrives in the same cycle as fetch_addr, and the decoder
// inputs are derived from id_instr.
module dbr_fetch_ctrl #(
    parameter int unsigned          ADDR_W    = 32,
    parameter int unsigned          INSTR_W   = 16,
    parameter int unsigned          DISP_W    = 8,
    parameter logic [ADDR_W-1:0]    RESET_VEC = 32'h0000_0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cond_flag,
    input  logic [INSTR_W-1:0] fetch_word,
    input  logic               dec_is_bcond,
    input  logic               dec_pol,
    input  logic [DISP_W-1:0]  dec_disp,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic               fetch_valid,
    output logic               kill,
    output logic               id_valid,
    output logic [INSTR_W-1:0] id_instr,
    output logic [ADDR_W-1:0]  id_pc,
    output logic               ex_valid,
    output logic [INSTR_W-1:0] ex_instr,
    output logic [ADDR_W-1:0]  ex_pc,
    output logic               slot_err
);

    localparam int unsigned STEP = INSTR_W / 8;

    logic              br_legal, br_taken, br_illegal;
    logic              ex_br, ex_taken, ex_err;
    logic [DISP_W-1:0] ex_disp;
    logic [ADDR_W-1:0] target;

    assign kill     = ex_valid && ex_taken;
    assign slot_err = ex_valid && ex_err;

    dbr_fetch_pc #(
        .ADDR_W(ADDR_W), .STEP(STEP), .RESET_VEC(RESET_VEC)
    ) pc_i (
        .clk(clk), .rst_n(rst_n),
        .redirect(kill), .redirect_addr(target),
        .fetch_addr(fetch_addr), .fetch_valid(fetch_valid)
    );

    dbr_stage_regs #(
        .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .DISP_W(DISP_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .kill(kill),
        .fetch_addr(fetch_addr), .fetch_word(fetch_word), .dec_disp(dec_disp),
        .br_legal(br_legal), .br_taken(br_taken), .br_illegal(br_illegal),
        .id_valid(id_valid), .id_instr(id_instr), .id_pc(id_pc),
        .ex_valid(ex_valid), .ex_instr(ex_instr), .ex_pc(ex_pc),
        .ex_disp(ex_disp), .ex_br(ex_br), .ex_taken(ex_taken), .ex_err(ex_err)
    );

    dbr_branch_unit #(
        .ADDR_W(ADDR_W), .DISP_W(DISP_W), .STEP(STEP)
    ) br_i (
        .id_valid(id_valid), .dec_is_bcond(dec_is_bcond), .dec_pol(dec_pol),
        .cond_flag(cond_flag), .ex_br(ex_br), .ex_pc(ex_pc), .ex_disp(ex_disp),
        .br_legal(br_legal), .br_taken(br_taken), .br_illegal(br_illegal),
        .target(target)
    );

    assert_slot_no_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_err |-> !kill);

    assert_delay_slot_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> ex_valid);

    assert_bubble_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> fetch_valid);

endmodule

// File: tb/dbr_fetch_ctrl_tb_top.sv
// Scoreboard bench: a reference walk of the program fills expected queues;
// a negedge monitor pops and compares executed addresses and redirects.
module dbr_fetch_ctrl_tb_top;

    localparam logic [31:0] RV  = 32'h0000_0100;
    localparam logic [15:0] NOP = 16'h0009;
    localparam logic [15:0] BT  = 16'h8E00;   // [15:10]=100011, [9]=1 branch on set flag
    localparam logic [15:0] BF  = 16'h8C00;   // [15:10]=100011, [9]=0 branch on clear flag
    localparam int          NEXEC = 30;

    typedef struct {
        logic [31:0] pc;
        logic        err;
        string       tag;
    } exp_t;

    typedef struct {
        logic [31:0] kaddr;
        logic [31:0] tgt;
    } kexp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cond_flag = 1'b0;
    logic [15:0] fetch_word;
    logic        dec_is_bcond, dec_pol;
    logic [7:0]  dec_disp;
    logic [31:0] fetch_addr, id_pc, ex_pc;
    logic        fetch_valid, kill, id_valid, ex_valid, slot_err;
    logic [15:0] id_instr, ex_instr;

    int checks = 0;
    int errors = 0;
    bit active = 1'b0;
    int kst = 0;
    logic [31:0] ktgt;

    exp_t  exp_q[$];
    kexp_t kq[$];

    always #10 clk = ~clk;

    function automatic logic [15:0] prog_word(input logic [31:0] a);
        int idx;
        if (a < RV) return NOP;
        idx = int'((a - RV) >> 1);
        case (idx)
            2:  return BT | 16'h0003;   // forward to idx 7
            4:  return BT | 16'h0000;   // sits in the discarded slot when idx 2 is taken
            7:  return BF | 16'h0002;   // forward to idx 11
            8:  return BT | 16'h0004;   // always in a delay slot: illegal
            11: return BT | 16'h00F8;   // backward to idx 5
            default: return NOP;
        endcase
    endfunction

    assign fetch_word   = prog_word(fetch_addr);
    assign dec_is_bcond = (id_instr[15:10] == 6'b100011);
    assign dec_pol      = id_instr[9];
    assign dec_disp     = id_instr[7:0];

    dbr_fetch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cond_flag(cond_flag), .fetch_word(fetch_word),
        .dec_is_bcond(dec_is_bcond), .dec_pol(dec_pol), .dec_disp(dec_disp),
        .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .kill(kill),
        .id_valid(id_valid), .id_instr(id_instr), .id_pc(id_pc),
        .ex_valid(ex_valid), .ex_instr(ex_instr), .ex_pc(ex_pc), .slot_err(slot_err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Driver: architectural walk of the program, pushing expected results.
    task automatic build_expect(input bit flag);
        logic [31:0] pc, tgt, nxt;
        logic [15:0] w;
        bit in_slot, taken, after_taken, after_nt;
        pc = RV; in_slot = 0; taken = 0; tgt = '0; after_taken = 0; after_nt = 0;
        exp_q.delete();
        kq.delete();
        for (int i = 0; i < NEXEC; i++) begin
            exp_t e;
            w = prog_word(pc);
            e.pc  = pc;
            e.err = in_slot && (w[15:10] == 6'b100011);
            if (e.err)            e.tag = "R8";
            else if (in_slot)     e.tag = "R4";
            else if (after_taken) e.tag = "R6";
            else if (after_nt)    e.tag = "R7";
            else                  e.tag = "R2";
            exp_q.push_back(e);
            after_taken = 0;
            after_nt    = 0;
            if (w[15:10] == 6'b100011 && !in_slot) begin
                kexp_t k;
                taken   = (w[9] == flag);
                tgt     = pc + 32'd4 + {{23{w[7]}}, w[7:0], 1'b0};
                in_slot = 1;
                nxt     = pc + 32'd2;
                if (taken) begin
                    k.kaddr = pc + 32'd4;
                    k.tgt   = tgt;
                    kq.push_back(k);
                end
            end else if (in_slot) begin
                in_slot = 0;
                nxt = taken ? tgt : pc + 32'd2;
                after_taken = taken;
                after_nt    = !taken;
            end else begin
                nxt = pc + 32'd2;
            end
            pc = nxt;
        end
    endtask

    // Monitor: compares executed instructions and the redirect sequence.
    always @(negedge clk) begin
        if (active) begin
            if (ex_valid && exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(ex_pc == e.pc, e.tag, "executed address", ex_pc, e.pc);
                chk(slot_err == e.err, "R8", "slot_err", 32'(slot_err), 32'(e.err));
            end
            if (kill) begin
                if (kq.size() == 0) begin
                    chk(1'b0, "R9", "unexpected kill", fetch_addr, 32'h0);
                end else begin
                    kexp_t k;
                    k = kq.pop_front();
                    chk(fetch_addr == k.kaddr && fetch_valid, "R3 R5",
                        "killed fetch address", fetch_addr, k.kaddr);
                    ktgt = k.tgt;
                    kst  = 1;
                end
            end else if (kst == 1) begin
                chk(!fetch_valid && !id_valid, "R5 R6", "dead slot valid bits",
                    {30'b0, fetch_valid, id_valid}, 32'h0);
                kst = 2;
            end else if (kst == 2) begin
                chk(fetch_valid && fetch_addr == ktgt, "R6", "target fetch",
                    fetch_addr, ktgt);
                kst = 0;
            end
        end
    end

    task automatic run_case(input bit flag);
        cond_flag = flag;
        rst_n = 1'b0;
        build_expect(flag);
        kst = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(fetch_addr == RV, "R1", "reset fetch address", fetch_addr, RV);
        chk(fetch_valid == 1'b1, "R1", "reset fetch_valid", 32'(fetch_valid), 32'h1);
        chk(!id_valid && !ex_valid && !kill && !slot_err, "R1", "reset stage state",
            {28'b0, id_valid, ex_valid, kill, slot_err}, 32'h0);
        active = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        @(posedge clk);
        active = 1'b0;
        chk(kq.size() == 0, "R9", "pending redirects left", 32'(kq.size()), 32'h0);
    endtask

    initial begin
        run_case(1'b1);
        run_case(1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule